// File: doc/BRIEF.md
# Built-In Test Pattern Generator

This block is a parallel stimulus source for driving a device under test with a `WIDTH`-bit word. A 3-bit mode select picks one of six standard sequences: plain binary counting, a twisted-ring (Johnson) count, a Gray-coded count, walking ones, walking zeros and an alternating checkerboard. Each clock with the enable high moves the output word one step along the chosen sequence.

The generator registers the mode select on every clock. When the presented code differs from the registered one, the generator takes the new code and reloads that sequence's starting word. The first word seen after the change is therefore the seed, and stepping resumes from there. A synchronous reset puts the generator into binary mode with a zero word.

Each sequence keeps its own small state register. A combinational selector drives the output from the registered mode, so the word changes in the same cycle as the state that produces it.

Top module: `tpg_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the generator enters binary mode (code 0) with `pattern` equal to zero after that edge.
- R2: Mode codes are 0 binary, 1 Johnson, 2 Gray, 3 walking ones, 4 walking zeros, 5 checkerboard. When `mode_sel` differs from the registered mode at a rising edge, the new code is taken and `pattern` shows that mode's seed after the edge, whether or not `enable` is high. The seeds are: zero for codes 0, 1 and 2; only bit 0 set for code 3; every bit except bit 0 set for code 4; and the word with the even-numbered bits set for code 5.
- R3: In binary mode each enabled step adds one to `pattern`, wrapping from all ones to zero.
- R4: In Johnson mode each enabled step shifts the word one place toward the MSB and feeds the inverted MSB into bit 0, giving a cycle of 2·`WIDTH` distinct words.
- R5: In Gray mode `pattern` is the Gray code of a step count, so exactly one bit changes on each enabled step, including the wrap.
- R6: In walking-ones mode exactly one bit is 1. Each enabled step moves it one place toward the MSB, and from the MSB it wraps to bit 0.
- R7: In walking-zeros mode exactly one bit is 0. It moves and wraps the same way as the set bit in R6.
- R8: In checkerboard mode `pattern` alternates on every enabled step between the even-bits-set word and the odd-bits-set word.
- R9: A clock with `enable` low and no mode change leaves `pattern` unchanged.
- R10: Codes 6 and 7 drive `pattern` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the sequence by one step on this edge |
| mode_sel | input | 3 | Requested sequence code |
| pattern | output | WIDTH | Generated word |

## Verification
The hardest cases to reach are the wrap points deep inside each sequence and a mode change that arrives mid-run with `enable` high. A mode change must restart the sequence and must not also advance it. The stimulus runs binary and Gray past their full 2^`WIDTH` cycle and runs Johnson and the walking modes past their wrap. It then switches modes in the middle of a run while `enable` stays high, and changes the mode during a stretch with `enable` low. A reference model keeps only a mode and a step count and derives every expected word from them arithmetically.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_BIN   = 3'd0,
    MODE_JOHN  = 3'd1,
    MODE_GRAY  = 3'd2,
    MODE_WALK1 = 3'd3,
    MODE_WALK0 = 3'd4,
    MODE_CHECK = 3'd5
  } tpg_mode_e;
endpackage

// File: rtl/tpg_count.sv
// Binary up-counter with a Gray-coded view of the same count.
module tpg_count #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [WIDTH-1:0] bin_o,
  output logic [WIDTH-1:0] gray_o
);
  function automatic logic [WIDTH-1:0] to_gray(input logic [WIDTH-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt_q <= '0;
    else if (advance)  cnt_q <= cnt_q + 1'b1;
  end

  assign bin_o  = cnt_q;
  assign gray_o = to_gray(cnt_q);

  // R3: one step adds exactly one (modulo the width)
  p_bin_step_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> bin_o == $past(bin_o) + 1'b1);

  // R5: Gray view changes exactly one bit per step
  p_gray_onebit_r5: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> $countones(gray_o ^ $past(gray_o)) == 1);
endmodule

// File: rtl/tpg_johnson.sv
// Twisted-ring counter: 2*WIDTH states.
module tpg_johnson #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [WIDTH-1:0] ring_o
);
  logic [WIDTH-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  ring_q <= '0;
    else if (advance)  ring_q <= {ring_q[WIDTH-2:0], ~ring_q[WIDTH-1]};
  end

  assign ring_o = ring_q;

  // R4: bit 0 takes the inverted old MSB
  p_john_feed_r4: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> ring_o[0] == !$past(ring_o[WIDTH-1]));

  // R4: the remaining bits move one place up
  p_john_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> ring_o[WIDTH-1:1] == $past(ring_o[WIDTH-2:0]));
endmodule

// File: rtl/tpg_walk.sv
// Rotating single-bit marker; ACTIVE_LOW picks the walking-zeros view.
module tpg_walk #(
  parameter int WIDTH      = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [WIDTH-1:0] walk_o
);
  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  logic [WIDTH-1:0] hot_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  hot_q <= SEED;
    else if (advance)  hot_q <= {hot_q[WIDTH-2:0], hot_q[WIDTH-1]};
  end

  generate
    if (ACTIVE_LOW) begin : g_zeros
      assign walk_o = ~hot_q;
    end else begin : g_ones
      assign walk_o = hot_q;
    end
  endgenerate

  // R6 / R7: exactly one marker bit at all times
  p_walk_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(hot_q) == 1);

  // R7: the marker wraps from the MSB to bit 0
  p_walk_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear && hot_q[WIDTH-1]) |=> hot_q[0]);
endmodule

// File: rtl/tpg_checker.sv
// Alternating checkerboard word.
module tpg_checker #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [WIDTH-1:0] board_o
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  phase_q <= 1'b0;
    else if (advance)  phase_q <= ~phase_q;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign board_o[i] = phase_q ^ ((i % 2) == 0);
    end
  endgenerate

  // R8: every step flips every bit
  p_check_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> board_o == ~$past(board_o));
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [2:0]       mode_sel,
  output logic [WIDTH-1:0] pattern
);
  import tpg_pkg::*;

  logic [MODE_W-1:0] mode_q;
  logic              mode_change;
  logic              step;
  logic [WIDTH-1:0]  bin_w, gray_w, john_w, w1_w, w0_w, chk_w;

  assign mode_change = (mode_sel != mode_q);
  assign step        = enable && !mode_change;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_BIN;
    else     mode_q <= mode_sel;
  end

  tpg_count #(.WIDTH(WIDTH)) u_count (
    .clk(clk), .rst(rst), .clear(mode_change),
    .advance(step && (mode_q == MODE_BIN || mode_q == MODE_GRAY)),
    .bin_o(bin_w), .gray_o(gray_w));

  tpg_johnson #(.WIDTH(WIDTH)) u_john (
    .clk(clk), .rst(rst), .clear(mode_change),
    .advance(step && mode_q == MODE_JOHN), .ring_o(john_w));

  tpg_walk #(.WIDTH(WIDTH), .ACTIVE_LOW(1'b0)) u_walk1 (
    .clk(clk), .rst(rst), .clear(mode_change),
    .advance(step && mode_q == MODE_WALK1), .walk_o(w1_w));

  tpg_walk #(.WIDTH(WIDTH), .ACTIVE_LOW(1'b1)) u_walk0 (
    .clk(clk), .rst(rst), .clear(mode_change),
    .advance(step && mode_q == MODE_WALK0), .walk_o(w0_w));

  tpg_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .clear(mode_change),
    .advance(step && mode_q == MODE_CHECK), .board_o(chk_w));

  always_comb begin
    case (mode_q)
      MODE_BIN:   pattern = bin_w;
      MODE_JOHN:  pattern = john_w;
      MODE_GRAY:  pattern = gray_w;
      MODE_WALK1: pattern = w1_w;
      MODE_WALK0: pattern = w0_w;
      MODE_CHECK: pattern = chk_w;
      default:    pattern = '0;   // R10
    endcase
  end

  // R9: idle clock leaves the word alone
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!enable && !mode_change) |=> $stable(pattern));

  // R2: switching to a counting mode starts from zero
  p_seed_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_change && mode_sel inside {3'd0, 3'd1, 3'd2}) |=> pattern == '0);

  // R2: switching to walking ones starts with bit 0 set
  p_seed_walk_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_change && mode_sel == 3'd3) |=> pattern == WIDTH'(1));

  // R1: reset lands in binary mode with a zero word
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pattern == '0 && mode_q == MODE_BIN));
endmodule

// File: tb/tb_tpg_top.sv
module tb_tpg_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic [2:0]   mode_sel = 3'd0;
  logic [W-1:0] pattern;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  // reference model state
  int ref_mode = 0;
  int ref_k = 0;

  always #5 clk = ~clk;

  tpg_top #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .enable(enable),
    .mode_sel(mode_sel), .pattern(pattern));

  function automatic logic [W-1:0] expect_word(input int m, input int k);
    logic [W-1:0] v;
    int j;
    v = '0;
    case (m)
      0: v = W'(k % (1 << W));
      1: begin
        j = k % (2 * W);
        if (j < W) v = W'((1 << j) - 1);
        else       v = W'((1 << W) - (1 << (j - W)));
      end
      2: begin
        j = k % (1 << W);
        v = W'(j ^ (j / 2));
      end
      3: v = W'(1 << (k % W));
      4: v = ~W'(1 << (k % W));
      5: for (int b = 0; b < W; b++) v[b] = ((b + k) % 2) == 0;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic cyc(input logic r, input logic en, input logic [2:0] sel);
    logic [W-1:0] exp_w;
    rst = r; enable = en; mode_sel = sel;
    @(posedge clk);
    if (r) begin
      ref_mode = 0; ref_k = 0;
    end else if (int'(sel) != ref_mode) begin
      ref_mode = int'(sel); ref_k = 0;
    end else if (en) begin
      ref_k = ref_k + 1;
    end
    @(negedge clk);
    exp_w = expect_word(ref_mode, ref_k);
    compared++;
    if (pattern !== exp_w) begin
      mismatched++;
      $display("FAIL %s: mode %0d step %0d pattern=%h expected=%h",
               cur_req, ref_mode, ref_k, pattern, exp_w);
    end
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    cyc(1, 0, 3'd5); cyc(1, 1, 3'd3); cyc(1, 0, 3'd0);
    // R3: full binary wrap
    cur_req = "R3";
    for (int i = 0; i < 300; i++) cyc(0, 1, 3'd0);
    // R9: idle clocks hold the word
    cur_req = "R9";
    for (int i = 0; i < 4; i++) cyc(0, 0, 3'd0);
    // R4: Johnson beyond 2W
    cur_req = "R4";
    for (int i = 0; i < 3 * W + 3; i++) cyc(0, 1, 3'd1);
    // R5: Gray full cycle plus wrap
    cur_req = "R5";
    for (int i = 0; i < 270; i++) cyc(0, 1, 3'd2);
    // R6: walking ones past the wrap
    cur_req = "R6";
    for (int i = 0; i < 2 * W + 2; i++) cyc(0, 1, 3'd3);
    // R7: walking zeros past the wrap
    cur_req = "R7";
    for (int i = 0; i < 2 * W + 2; i++) cyc(0, 1, 3'd4);
    // R8: checkerboard alternation
    cur_req = "R8";
    for (int i = 0; i < 7; i++) cyc(0, 1, 3'd5);
    // R10: undefined codes
    cur_req = "R10";
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'd6);
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'd7);
    // R2: mid-run changes, enable high and low
    cur_req = "R2";
    for (int i = 0; i < 5; i++) cyc(0, 1, 3'd0);
    cyc(0, 1, 3'd3); cyc(0, 1, 3'd3); cyc(0, 1, 3'd1);
    cyc(0, 1, 3'd1); cyc(0, 1, 3'd1); cyc(0, 0, 3'd4);
    cyc(0, 0, 3'd4); cyc(0, 0, 3'd5); cyc(0, 1, 3'd5);
    cyc(0, 0, 3'd2); cyc(0, 1, 3'd2); cyc(0, 1, 3'd3);
    // R9: hold inside walking zeros
    cur_req = "R9";
    cyc(0, 1, 3'd4); cyc(0, 1, 3'd4);
    for (int i = 0; i < 3; i++) cyc(0, 0, 3'd4);
    // R1: reset mid-run
    cur_req = "R1";
    cyc(1, 1, 3'd4); cyc(0, 1, 3'd0); cyc(0, 1, 3'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule